// File: doc/BRIEF.md
# Auto-Ranging Frequency Counter

This block measures the frequency of an external pulse train and turns each measurement into a reading that a 3 1/2-digit display can show directly. A gate timer runs from the system clock. Over each gate the block counts rising edges of the synchronized input. At the end of the gate the count becomes a frequency in hertz. The block picks one of five decades for it and presents four BCD digits, a decimal-point code, a kHz/MHz flag and an overrange flag. A one-cycle strobe marks each new reading.

Set `GATE_CYCLES` to the system clock rate to get one reading per second. For example, use 40000 with a 40 kHz oscillator. `HZ_PER_EDGE` gives the number of hertz that one counted edge stands for. It is 1 when the input is counted directly, and it equals the division ratio when an external divider sits in front of the block. Each reading depends only on its own gate, because the edge count restarts from zero when a gate closes. The outputs keep their value until the next strobe.

Top module: `freq_autorange`

## Requirements
- R1: While rst_n is low and after it is released, until the first strobe, disp_bcd, dp_sel, unit_mhz, over_range and reading_stb are all 0.
- R2: reading_stb is high for exactly one cycle, and consecutive strobes are exactly GATE_CYCLES cycles apart.
- R3: Only rising edges of freq_in count, after a two-flop synchronizer. A level held across a gate boundary adds nothing to the next gate. The measured frequency F equals the number of edges in the gate multiplied by HZ_PER_EDGE.
- R4: If F < 2000, the reading is F, dp_sel = 3 (point after the leading digit, x.xxx) and unit_mhz = 0.
- R5: If 2000 <= F < 20000, the reading is F/10 truncated, dp_sel = 2 (xx.xx) and unit_mhz = 0.
- R6: If 20000 <= F < 200000, the reading is F/100 truncated, dp_sel = 1 (xxx.x) and unit_mhz = 0.
- R7: If 200000 <= F < 2000000, the reading is F/1000 truncated, dp_sel = 0 (no point) and unit_mhz = 0.
- R8: If 2000000 <= F < 20000000, the reading is F/10000 truncated, dp_sel = 2 and unit_mhz = 1.
- R9: If F >= 20000000, over_range = 1, disp_bcd = 0, dp_sel = 0 and unit_mhz = 1. Otherwise over_range = 0.
- R10: The reading is packed as four BCD digits, the most significant in disp_bcd[15:12] and the least in disp_bcd[3:0]. Every digit is at most 9 and the leading digit is 0 or 1.
- R11: The outputs change only in the cycle in which reading_stb is high. Between strobes they hold the previous reading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the time base for the gate |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_in | input | 1 | Asynchronous pulse input to be measured |
| disp_bcd | output | 16 | Four BCD digits of the reading, leading digit at the top |
| dp_sel | output | 2 | Decimal point code: 0 none, 1 xxx.x, 2 xx.xx, 3 x.xxx |
| unit_mhz | output | 1 | 1 selects the MHz annunciator, 0 the kHz annunciator |
| over_range | output | 1 | Reading exceeds the top decade |
| reading_stb | output | 1 | One-cycle pulse when a new reading is presented |

## Verification
A wrong edge count or a count that failed to restart would show at the next strobe as digits off by the scaled error. A broken gate timer would show as a strobe spacing other than GATE_CYCLES on the second strobe. A wrong decade selection is visible at once in dp_sel and unit_mhz. The decade edges are therefore probed with edge counts that put F just below and just above each threshold, including the overrange limit. A misplaced update would show between strobes as outputs that change mid-gate.

// File: rtl/fcr_pkg.sv
package fcr_pkg;

  localparam int unsigned NUM_DECADES = 5;
  localparam int unsigned FIRST_LIMIT = 2000;
  localparam int unsigned QUO_W       = 11;

  typedef enum logic [1:0] {
    DP_NONE  = 2'd0,
    DP_ONE   = 2'd1,
    DP_TWO   = 2'd2,
    DP_THREE = 2'd3
  } dp_code_t;

  typedef struct packed {
    logic [15:0] bcd;
    dp_code_t    dp;
    logic        mhz;
    logic        ovr;
  } reading_t;

  function automatic longint unsigned pow10(input int unsigned k);
    longint unsigned p;
    p = 1;
    for (int unsigned i = 0; i < k; i++) p = p * 10;
    return p;
  endfunction

  function automatic logic [15:0] to_bcd4(input logic [QUO_W-1:0] v);
    logic [15:0] acc;
    acc = '0;
    for (int i = QUO_W - 1; i >= 0; i--) begin
      for (int d = 0; d < 4; d++) begin
        if (acc[d*4 +: 4] >= 4'd5) acc[d*4 +: 4] = acc[d*4 +: 4] + 4'd3;
      end
      acc = {acc[14:0], v[i]};
    end
    return acc;
  endfunction

  function automatic dp_code_t dp_for_decade(input logic [2:0] r);
    case (r)
      3'd0:    return DP_THREE;
      3'd1:    return DP_TWO;
      3'd2:    return DP_ONE;
      3'd4:    return DP_TWO;
      default: return DP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/fcr_sync.sv
module fcr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], async_in};
  end

  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/fcr_gate.sv
module fcr_gate #(
  parameter int unsigned GATE_CYCLES = 40000
) (
  input  logic clk,
  input  logic rst_n,
  output logic gate_end
);
  localparam int unsigned TW = (GATE_CYCLES > 1) ? $clog2(GATE_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(GATE_CYCLES - 1);

  logic [TW-1:0] tick;

  assign gate_end = (tick == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)        tick <= '0;
    else if (gate_end) tick <= '0;
    else               tick <= tick + 1'b1;
  end
endmodule

// File: rtl/fcr_edge_acc.sv
module fcr_edge_acc #(
  parameter int unsigned EDGE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              gate_end,
  output logic [EDGE_W-1:0] total,
  output logic              total_vld
);
  logic [EDGE_W-1:0] run;
  logic [EDGE_W-1:0] run_next;

  assign run_next = run + EDGE_W'(rise);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run       <= '0;
      total     <= '0;
      total_vld <= 1'b0;
    end else begin
      total_vld <= gate_end;
      if (gate_end) begin
        total <= run_next;
        run   <= '0;
      end else begin
        run <= run_next;
      end
    end
  end
endmodule

// File: rtl/fcr_ranger.sv
module fcr_ranger
  import fcr_pkg::*;
#(
  parameter int unsigned COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COUNT_W-1:0] hz,
  input  logic               hz_vld,
  output reading_t           rd,
  output logic               rd_stb
);
  logic [NUM_DECADES-1:0] at_or_above;
  logic [QUO_W-1:0]       quo [NUM_DECADES];
  logic [2:0]             decade;
  reading_t               rd_next;

  for (genvar k = 0; k < NUM_DECADES; k++) begin : g_decade
    localparam logic [COUNT_W-1:0] DIV_K = COUNT_W'(pow10(k));
    localparam logic [COUNT_W-1:0] LIM_K = COUNT_W'(FIRST_LIMIT * pow10(k));
    logic [COUNT_W-1:0] q_full;
    assign q_full         = hz / DIV_K;
    assign quo[k]         = q_full[QUO_W-1:0];
    assign at_or_above[k] = (hz >= LIM_K);
  end

  // thresholds are increasing, so the set bits form a run from bit 0
  assign decade = 3'($countones(at_or_above));

  always_comb begin
    rd_next = '0;
    if (decade >= 3'(NUM_DECADES)) begin
      rd_next.ovr = 1'b1;
      rd_next.mhz = 1'b1;
      rd_next.dp  = DP_NONE;
    end else begin
      rd_next.bcd = to_bcd4(quo[decade]);
      rd_next.dp  = dp_for_decade(decade);
      rd_next.mhz = (decade == 3'd4);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd     <= '0;
      rd_stb <= 1'b0;
    end else begin
      rd_stb <= hz_vld;
      if (hz_vld) rd <= rd_next;
    end
  end
endmodule

// File: rtl/freq_autorange.sv
module freq_autorange
  import fcr_pkg::*;
#(
  parameter int unsigned GATE_CYCLES = 40000,
  parameter int unsigned HZ_PER_EDGE = 1,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned COUNT_W     = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        freq_in,
  output logic [15:0] disp_bcd,
  output logic [1:0]  dp_sel,
  output logic        unit_mhz,
  output logic        over_range,
  output logic        reading_stb
);
  localparam int unsigned EDGE_W = $clog2(GATE_CYCLES + 1);

  logic              rise;
  logic              gate_end;
  logic [EDGE_W-1:0] edge_total;
  logic              edge_total_vld;
  logic [COUNT_W-1:0] hz;
  reading_t          rd;

  fcr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(freq_in), .rise(rise)
  );

  fcr_gate #(.GATE_CYCLES(GATE_CYCLES)) u_gate (
    .clk(clk), .rst_n(rst_n), .gate_end(gate_end)
  );

  fcr_edge_acc #(.EDGE_W(EDGE_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .rise(rise), .gate_end(gate_end),
    .total(edge_total), .total_vld(edge_total_vld)
  );

  assign hz = COUNT_W'(edge_total) * COUNT_W'(HZ_PER_EDGE);

  fcr_ranger #(.COUNT_W(COUNT_W)) u_rng (
    .clk(clk), .rst_n(rst_n), .hz(hz), .hz_vld(edge_total_vld),
    .rd(rd), .rd_stb(reading_stb)
  );

  assign disp_bcd   = rd.bcd;
  assign dp_sel     = rd.dp;
  assign unit_mhz   = rd.mhz;
  assign over_range = rd.ovr;
endmodule

// File: rtl/fcr_checker.sv
module fcr_checker #(
  parameter int unsigned GATE_CYCLES = 40000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        gate_end,
  input logic        reading_stb,
  input logic [15:0] disp_bcd,
  input logic [1:0]  dp_sel,
  input logic        unit_mhz,
  input logic        over_range
);
  logic [31:0] since_stb;
  logic        stb_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_stb <= '0;
      stb_seen  <= 1'b0;
    end else if (reading_stb) begin
      since_stb <= '0;
      stb_seen  <= 1'b1;
    end else begin
      since_stb <= since_stb + 1;
    end
  end

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reading_stb |=> !reading_stb); // R2
  AST_STB_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (reading_stb && stb_seen) |-> (since_stb == GATE_CYCLES - 1)); // R2
  AST_STB_AFTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    gate_end |=> ##1 reading_stb); // R2
  AST_OL_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    over_range |-> (disp_bcd == 16'h0 && dp_sel == 2'd0 && unit_mhz)); // R9
  AST_MHZ_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_mhz && !over_range) |-> (dp_sel == 2'd2)); // R8
  AST_LEAD_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
    disp_bcd[15:12] <= 4'd1); // R10
  AST_BCD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_bcd[11:8] <= 4'd9 && disp_bcd[7:4] <= 4'd9 && disp_bcd[3:0] <= 4'd9)); // R10
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !reading_stb |-> ($stable(disp_bcd) && $stable(dp_sel) && $stable(unit_mhz) && $stable(over_range))); // R11
endmodule

bind freq_autorange fcr_checker #(.GATE_CYCLES(GATE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .gate_end(gate_end), .reading_stb(reading_stb),
  .disp_bcd(disp_bcd), .dp_sel(dp_sel), .unit_mhz(unit_mhz), .over_range(over_range)
);

// File: tb/tb_freq_autorange.sv
`timescale 1ns/1ps
module tb_freq_autorange;
  localparam int unsigned GATE = 10000;
  localparam int unsigned W    = 10007;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fin = 1'b0;
  logic [15:0] disp_bcd;
  logic [1:0]  dp_sel;
  logic        unit_mhz, over_range, reading_stb;

  int checks = 0;
  int errors = 0;
  longint unsigned cyc = 0;
  longint unsigned last_stb_cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  freq_autorange #(.GATE_CYCLES(GATE), .HZ_PER_EDGE(W)) dut (
    .clk(clk), .rst_n(rst_n), .freq_in(fin), .disp_bcd(disp_bcd), .dp_sel(dp_sel),
    .unit_mhz(unit_mhz), .over_range(over_range), .reading_stb(reading_stb)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int decade_of(input longint unsigned f);
    longint unsigned lim = 2000;
    int r = 0;
    while (r < 5 && f >= lim) begin r++; lim = lim * 10; end
    return r;
  endfunction

  function automatic logic [15:0] exp_bcd(input longint unsigned f);
    int r = decade_of(f);
    longint unsigned q = f;
    logic [15:0] b = '0;
    if (r == 5) return 16'h0;
    for (int i = 0; i < r; i++) q = q / 10;
    for (int d = 0; d < 4; d++) begin b[d*4 +: 4] = 4'(q % 10); q = q / 10; end
    return b;
  endfunction

  function automatic int exp_dp(input longint unsigned f);
    case (decade_of(f))
      0: return 3; 1: return 2; 2: return 1; 4: return 2; default: return 0;
    endcase
  endfunction

  function automatic string req_of(input longint unsigned f);
    case (decade_of(f))
      0: return "R4"; 1: return "R5"; 2: return "R6"; 3: return "R7"; 4: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic wait_stb(input bit check_gap);
    do @(negedge clk); while (!reading_stb);
    if (check_gap) chk("R2 strobe spacing", longint'(cyc - last_stb_cyc), longint'(GATE));
    last_stb_cyc = cyc;
    @(negedge clk);
    chk("R2 strobe width", reading_stb, 0);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) fin = 1'b1;
      @(negedge clk);
      @(negedge clk) fin = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic check_reading(input int n, input string tag);
    longint unsigned f = longint'(n) * W;
    string rq = req_of(f);
    chk({rq, " ", tag, " digits"}, disp_bcd, exp_bcd(f));
    chk({rq, " ", tag, " point"}, dp_sel, exp_dp(f));
    chk({rq, " ", tag, " unit"}, unit_mhz, (decade_of(f) >= 4) ? 1 : 0);
    chk({"R9 ", tag, " overrange flag"}, over_range, (decade_of(f) == 5) ? 1 : 0);
    chk({"R10 ", tag, " lead digit"}, (disp_bcd[15:12] <= 4'd1) ? 1 : 0, 1);
  endtask

  task automatic measure(input int n, input string tag);
    logic [15:0] prev_bcd;
    logic [1:0]  prev_dp;
    prev_bcd = disp_bcd;
    prev_dp  = dp_sel;
    pulses(n);
    chk({"R11 hold digits ", tag}, disp_bcd, prev_bcd);
    chk({"R11 hold point ", tag}, dp_sel, prev_dp);
    wait_stb(1);
    check_reading(n, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(1234);
    repeat (5) @(negedge clk);
    chk("R1 reset digits", disp_bcd, 0);
    chk("R1 reset flags", {dp_sel, unit_mhz, over_range, reading_stb}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {disp_bcd, dp_sel, unit_mhz, over_range, reading_stb}, 0);
    wait_stb(0);
    check_reading(0, "idle gate");

    measure(1, "one edge");        // R5 lower edge region
    measure(2, "two edges");       // R6 boundary
    measure(19, "below R7");       // R6 top
    measure(20, "R7 start");
    measure(199, "R7 top");
    measure(200, "R8 start");
    measure(1998, "R8 top");
    measure(1999, "R9 limit");

    // R3: one rising edge held high across the boundary, then nothing
    @(negedge clk) fin = 1'b1;
    wait_stb(1);
    check_reading(1, "R3 held high");
    wait_stb(1);
    check_reading(0, "R3 level only");
    fin = 1'b0;
    wait_stb(1);
    check_reading(0, "R3 falling only");

    for (int t = 0; t < 3; t++) begin
      int n;
      n = int'($urandom_range(2200, 0));
      measure(n, "random");
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule